// File: doc/BRIEF.md
# Dual-Path Add/Subtract Execution Unit

This unit executes one paired arithmetic instruction of a SIMD extension. A single 32-bit instruction word names two source registers and two destination registers of a 16-entry, 32-bit register file. Both sources feed two independent arithmetic paths, called path A and path D. A two-bit pattern field sets each path to add or to subtract, so one instruction can produce a sum and a difference of the same operand pair, two sums, or two differences.

The register file is outside the unit. The unit drives the two read indices straight from the instruction word and samples the read data on the edge where the valid strobe is high. One clock later it presents up to two registered write ports, the updated control register and a one-cycle done pulse. For each path that writes, a carry/borrow flag is stored at a fixed high bit of the control register. The unit holds that register and leaves all its other bits unchanged.

Register 0 acts as a constant zero. Reading it yields zero, and a path whose destination is register 0 is switched off. An instruction with non-zero padding is accepted but changes nothing.

Top module: `dual_addsub_unit`

## Requirements
- R1: The instruction is recognised when `instr_valid` is high, bits 5:0 equal 0x18 and bits 31:26 equal `MAJOR_OPC` (default 0x1C). Other bits are decoded as: 25:24 pattern, 23:22 padding, 21:18 destination D, 17:14 source C, 13:10 source B, 9:6 destination A. A word that does not match produces no done pulse and no write.
- R2: Each recognised instruction gives exactly one `done` pulse, one cycle after the valid edge. Any writes and control-register update appear in that same cycle, and never without `done`.
- R3: Path A writes B+C to destination A when pattern bit 1 (word bit 25) is 0, and B−C when it is 1, modulo 2^32.
- R4: Path D writes B+C to destination D when pattern bit 0 (word bit 24) is 0, and B−C when it is 1, modulo 2^32.
- R5: For an adding path, the flag is 1 exactly when B is unsigned-greater than the truncated sum, which is the carry out.
- R6: For a subtracting path, the flag is 1 exactly when B is unsigned-greater than C.
- R7: Path A's flag is stored in control bit 31 and path D's flag in bit 30. Bits 29:0 never change after reset.
- R8: A recognised instruction with non-zero padding writes no register and leaves the whole control register unchanged.
- R9: A path whose destination index is 0 neither writes nor updates its flag bit, while the other path still executes. When both destinations are 0, nothing changes.
- R10: A source index of 0 supplies the operand value zero, whatever the register file returns for that index.
- R11: After synchronous reset, the control register holds `CTRL_INIT`, and `done` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| rd_idx_b | output | 4 | Read index for source B (combinational from the word) |
| rd_idx_c | output | 4 | Read index for source C (combinational from the word) |
| rd_data_b | input | DATA_W | Register-file data for source B |
| rd_data_c | input | DATA_W | Register-file data for source C |
| wr_en_a | output | 1 | Write enable, path A |
| wr_idx_a | output | 4 | Destination index, path A |
| wr_data_a | output | DATA_W | Result, path A |
| wr_en_d | output | 1 | Write enable, path D |
| wr_idx_d | output | 4 | Destination index, path D |
| wr_data_d | output | DATA_W | Result, path D |
| ctrl_q | output | DATA_W | Control register with the two path flags |
| done | output | 1 | One-cycle completion pulse |

## Verification
All four pattern values are swept with fixed corner operand pairs and with random pairs. The corner pairs include zero plus zero, all-ones plus one, equal operands and operands one apart, plus the sign-bit pair. These show whether the add flag comes from the carry out or from a wrong compare, and whether the subtract flag uses strict greater-than, since equal operands must give 0. Because each path has its own mode, patterns 1 and 2 separate the two mode bits and catch a swap between the paths. Further cases cover non-zero padding, each single zero destination and the double one, mismatching opcodes, and a zero source index fed with junk data. Every case compares the full control register, so any change to the low bits is exposed.

// File: rtl/dual_addsub_pkg.sv
package dual_addsub_pkg;

  localparam int INSTR_W = 32;
  localparam int IDX_W   = 4;
  localparam int NLANES  = 2;

  localparam logic [5:0] OPC_MINOR       = 6'h18;
  localparam logic [5:0] OPC_MAJOR_DFLT  = 6'h1C;

  // lane 0 = path A, lane 1 = path D
  typedef struct packed {
    logic [5:0]       major;
    logic [1:0]       pattern;
    logic [1:0]       pad;
    logic [IDX_W-1:0] dst_d;
    logic [IDX_W-1:0] src_c;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] dst_a;
    logic [5:0]       minor;
  } instr_t;

endpackage

// File: rtl/dual_addsub_decode.sv
module dual_addsub_decode
  import dual_addsub_pkg::*;
#(
  parameter logic [5:0] MAJOR_OPC = OPC_MAJOR_DFLT
) (
  input  logic                        valid,
  input  logic [INSTR_W-1:0]          word,
  output logic                        hit,
  output logic [NLANES-1:0]           lane_en,
  output logic [NLANES-1:0]           lane_sub,
  output logic [NLANES-1:0][IDX_W-1:0] lane_dst,
  output logic [IDX_W-1:0]            src_b,
  output logic [IDX_W-1:0]            src_c
);

  instr_t f;
  logic   pad_clean;

  always_comb begin
    f         = instr_t'(word);
    hit       = valid && (f.minor == OPC_MINOR) && (f.major == MAJOR_OPC);
    pad_clean = (f.pad == 2'b00);
    src_b     = f.src_b;
    src_c     = f.src_c;
    lane_dst[0] = f.dst_a;
    lane_dst[1] = f.dst_d;
    // pattern bit 1 steers path A, bit 0 steers path D
    lane_sub[0] = f.pattern[1];
    lane_sub[1] = f.pattern[0];
    for (int i = 0; i < NLANES; i++) begin
      lane_en[i] = hit && pad_clean && (lane_dst[i] != '0);
    end
  end

endmodule

// File: rtl/dual_addsub_lane.sv
module dual_addsub_lane #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_c,
  input  logic              sub_sel,
  output logic [DATA_W-1:0] result,
  output logic              flag
);

  logic [DATA_W-1:0] sum_v;
  logic [DATA_W-1:0] diff_v;

  always_comb begin
    sum_v  = opnd_b + opnd_c;
    diff_v = opnd_b - opnd_c;
    if (sub_sel) begin
      result = diff_v;
      flag   = (opnd_b > opnd_c);
    end else begin
      result = sum_v;
      flag   = (opnd_b > sum_v);
    end
  end

endmodule

// File: rtl/dual_addsub_unit.sv
module dual_addsub_unit
  import dual_addsub_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [5:0]  MAJOR_OPC = OPC_MAJOR_DFLT,
  parameter logic [DATA_W-1:0] CTRL_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr_word,
  output logic [IDX_W-1:0]     rd_idx_b,
  output logic [IDX_W-1:0]     rd_idx_c,
  input  logic [DATA_W-1:0]    rd_data_b,
  input  logic [DATA_W-1:0]    rd_data_c,
  output logic                 wr_en_a,
  output logic [IDX_W-1:0]     wr_idx_a,
  output logic [DATA_W-1:0]    wr_data_a,
  output logic                 wr_en_d,
  output logic [IDX_W-1:0]     wr_idx_d,
  output logic [DATA_W-1:0]    wr_data_d,
  output logic [DATA_W-1:0]    ctrl_q,
  output logic                 done
);

  localparam int FLAG_TOP = DATA_W - 1;

  logic                         hit;
  logic [NLANES-1:0]            lane_en;
  logic [NLANES-1:0]            lane_sub;
  logic [NLANES-1:0][IDX_W-1:0] lane_dst;
  logic [NLANES-1:0][DATA_W-1:0] lane_res;
  logic [NLANES-1:0]            lane_flag;
  logic [IDX_W-1:0]             src_b;
  logic [IDX_W-1:0]             src_c;
  logic [DATA_W-1:0]            opnd_b;
  logic [DATA_W-1:0]            opnd_c;

  logic [NLANES-1:0]            wen_q;
  logic [NLANES-1:0][IDX_W-1:0] widx_q;
  logic [NLANES-1:0][DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0]            ctrl_r;
  logic                         done_r;

  dual_addsub_decode #(.MAJOR_OPC(MAJOR_OPC)) dec_i (
    .valid    (instr_valid),
    .word     (instr_word),
    .hit      (hit),
    .lane_en  (lane_en),
    .lane_sub (lane_sub),
    .lane_dst (lane_dst),
    .src_b    (src_b),
    .src_c    (src_c)
  );

  assign rd_idx_b = src_b;
  assign rd_idx_c = src_c;

  // register 0 is a hard zero
  assign opnd_b = (src_b == '0) ? '0 : rd_data_b;
  assign opnd_c = (src_c == '0) ? '0 : rd_data_c;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    dual_addsub_lane #(.DATA_W(DATA_W)) lane_i (
      .opnd_b  (opnd_b),
      .opnd_c  (opnd_c),
      .sub_sel (lane_sub[g]),
      .result  (lane_res[g]),
      .flag    (lane_flag[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        wen_q[g]  <= 1'b0;
        widx_q[g] <= '0;
        wdat_q[g] <= '0;
      end else begin
        wen_q[g] <= lane_en[g];
        if (lane_en[g]) begin
          widx_q[g] <= lane_dst[g];
          wdat_q[g] <= lane_res[g];
        end
      end
    end
  end

  // flag of lane i lands at bit FLAG_TOP-i
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r <= CTRL_INIT;
      done_r <= 1'b0;
    end else begin
      done_r <= hit;
      for (int i = 0; i < NLANES; i++) begin
        if (lane_en[i]) ctrl_r[FLAG_TOP-i] <= lane_flag[i];
      end
    end
  end

  assign wr_en_a   = wen_q[0];
  assign wr_idx_a  = widx_q[0];
  assign wr_data_a = wdat_q[0];
  assign wr_en_d   = wen_q[1];
  assign wr_idx_d  = widx_q[1];
  assign wr_data_d = wdat_q[1];
  assign ctrl_q    = ctrl_r;
  assign done      = done_r;

endmodule

// File: rtl/dual_addsub_unit_chk.sv
module dual_addsub_unit_chk
  import dual_addsub_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter logic [5:0] MAJOR_OPC = OPC_MAJOR_DFLT
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 instr_valid,
  input logic [INSTR_W-1:0]   instr_word,
  input logic [IDX_W-1:0]     rd_idx_b,
  input logic [IDX_W-1:0]     rd_idx_c,
  input logic [DATA_W-1:0]    rd_data_b,
  input logic [DATA_W-1:0]    rd_data_c,
  input logic                 wr_en_a,
  input logic [IDX_W-1:0]     wr_idx_a,
  input logic [DATA_W-1:0]    wr_data_a,
  input logic                 wr_en_d,
  input logic [IDX_W-1:0]     wr_idx_d,
  input logic [DATA_W-1:0]    wr_data_d,
  input logic [DATA_W-1:0]    ctrl_q,
  input logic                 done
);

  logic match;
  assign match = instr_valid && (instr_word[5:0] == OPC_MINOR)
                 && (instr_word[31:26] == MAJOR_OPC);

  a_r2_done_follows: assert property (@(posedge clk) disable iff (rst)
    match |=> done);

  a_r1_no_done_unmatched: assert property (@(posedge clk) disable iff (rst)
    !match |=> !done);

  a_r2_writes_with_done: assert property (@(posedge clk) disable iff (rst)
    (wr_en_a || wr_en_d) |-> done);

  a_r9_no_zero_dest_a: assert property (@(posedge clk) disable iff (rst)
    wr_en_a |-> (wr_idx_a != '0));

  a_r9_no_zero_dest_d: assert property (@(posedge clk) disable iff (rst)
    wr_en_d |-> (wr_idx_d != '0));

  a_r3_dest_a_index: assert property (@(posedge clk) disable iff (rst)
    wr_en_a |-> (wr_idx_a == $past(instr_word[9:6])));

  a_r4_dest_d_index: assert property (@(posedge clk) disable iff (rst)
    wr_en_d |-> (wr_idx_d == $past(instr_word[21:18])));

  a_r7_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
    $stable(ctrl_q[DATA_W-3:0]));

  a_r9_flag_a_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en_a |-> (ctrl_q[DATA_W-1] == $past(ctrl_q[DATA_W-1])));

  a_r9_flag_d_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en_d |-> (ctrl_q[DATA_W-2] == $past(ctrl_q[DATA_W-2])));

  a_r8_pad_blocks: assert property (@(posedge clk) disable iff (rst)
    (match && (instr_word[23:22] != 2'b00)) |=>
      (!wr_en_a && !wr_en_d && $stable(ctrl_q)));

endmodule

bind dual_addsub_unit dual_addsub_unit_chk #(
  .DATA_W    (DATA_W),
  .MAJOR_OPC (MAJOR_OPC)
) chk_i (.*);

// File: tb/dual_addsub_unit_tb_top.sv
module dual_addsub_unit_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] CINIT = 32'h2A5C_39E1;
  localparam logic [31:0] JUNK  = 32'hDEAD_BEEF;
  localparam logic [5:0]  MAJ   = 6'h1C;
  localparam logic [5:0]  MIN   = 6'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [3:0]  rd_idx_b, rd_idx_c;
  logic [31:0] rd_data_b, rd_data_c;
  logic        wr_en_a, wr_en_d, done;
  logic [3:0]  wr_idx_a, wr_idx_d;
  logic [31:0] wr_data_a, wr_data_d, ctrl_q;

  logic [31:0] bank [16];
  logic [31:0] exp_ctrl;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  assign rd_data_b = (rd_idx_b == 4'd0) ? JUNK : bank[rd_idx_b];
  assign rd_data_c = (rd_idx_c == 4'd0) ? ~JUNK : bank[rd_idx_c];

  dual_addsub_unit #(.DATA_W(32), .MAJOR_OPC(MAJ), .CTRL_INIT(CINIT)) dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .rd_idx_b(rd_idx_b), .rd_idx_c(rd_idx_c),
    .rd_data_b(rd_data_b), .rd_data_c(rd_data_c),
    .wr_en_a(wr_en_a), .wr_idx_a(wr_idx_a), .wr_data_a(wr_data_a),
    .wr_en_d(wr_en_d), .wr_idx_d(wr_idx_d), .wr_data_d(wr_data_d),
    .ctrl_q(ctrl_q), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [1:0] pat,
      input logic [1:0] pad, input logic [3:0] d, input logic [3:0] c,
      input logic [3:0] b, input logic [3:0] a, input logic [5:0] mn);
    return {maj, pat, pad, d, c, b, a, mn};
  endfunction

  // issue one word at a negedge, check the registered outputs at the next negedge
  task automatic run(input logic [31:0] w);
    logic [1:0] pat, pad;
    logic [3:0] a, b, c, d;
    logic [31:0] bv, cv, ra, rd;
    logic hit, ea, ed, fa, fd;
    logic [32:0] wide;
    pat = w[25:24]; pad = w[23:22]; d = w[21:18]; c = w[17:14];
    b = w[13:10]; a = w[9:6];
    hit = (w[5:0] == MIN) && (w[31:26] == MAJ);
    bv = (b == 0) ? 32'd0 : bank[b];
    cv = (c == 0) ? 32'd0 : bank[c];
    ea = hit && (pad == 0) && (a != 0);
    ed = hit && (pad == 0) && (d != 0);
    wide = {1'b0, bv} + {1'b0, cv};
    ra = pat[1] ? bv - cv : wide[31:0];
    fa = pat[1] ? (bv > cv) : wide[32];
    rd = pat[0] ? bv - cv : wide[31:0];
    fd = pat[0] ? (bv > cv) : wide[32];
    instr_word = w;
    instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(hit ? "R2 done" : "R1 done", {31'd0, done}, {31'd0, hit});
    chk((pad != 0) ? "R8 wr_en_a" : "R9 wr_en_a", {31'd0, wr_en_a}, {31'd0, ea});
    chk((pad != 0) ? "R8 wr_en_d" : "R9 wr_en_d", {31'd0, wr_en_d}, {31'd0, ed});
    if (ea) begin
      chk("R3 idx_a", {28'd0, wr_idx_a}, {28'd0, a});
      chk("R3 data_a", wr_data_a, ra);
      chk(pat[1] ? "R6 flag_a" : "R5 flag_a", {31'd0, ctrl_q[31]}, {31'd0, fa});
      exp_ctrl[31] = fa;
    end
    if (ed) begin
      chk("R4 idx_d", {28'd0, wr_idx_d}, {28'd0, d});
      chk("R4 data_d", wr_data_d, rd);
      chk(pat[0] ? "R6 flag_d" : "R5 flag_d", {31'd0, ctrl_q[30]}, {31'd0, fd});
      exp_ctrl[30] = fd;
    end
    chk((pad != 0) ? "R8 ctrl" : "R7 ctrl", ctrl_q, exp_ctrl);
    if (ea) bank[a] = ra;
    if (ed) bank[d] = rd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] cb [8];
    logic [31:0] cc [8];
    cb[0] = 32'h0;        cc[0] = 32'h0;
    cb[1] = 32'hFFFFFFFF; cc[1] = 32'h1;
    cb[2] = 32'h1;        cc[2] = 32'hFFFFFFFF;
    cb[3] = 32'h80000000; cc[3] = 32'h80000000;
    cb[4] = 32'h5;        cc[4] = 32'h5;
    cb[5] = 32'h5;        cc[5] = 32'h6;
    cb[6] = 32'h6;        cc[6] = 32'h5;
    cb[7] = 32'hFFFFFFFF; cc[7] = 32'hFFFFFFFF;
    bank[0] = 32'd0;
    for (int i = 1; i < 16; i++) bank[i] = $urandom;
    exp_ctrl = CINIT;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 ctrl", ctrl_q, CINIT);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 wr_en", {30'd0, wr_en_a, wr_en_d}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ctrl after release", ctrl_q, CINIT);

    // main sweep over all patterns, corner then random operands
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 40; n++) begin
        logic [3:0] a, d, b, c;
        a = 4'(1 + ($urandom % 15));
        d = 4'(1 + ((a + ($urandom % 14)) % 15));
        b = 4'(1 + ($urandom % 15));
        c = (n < 8) ? 4'(1 + ((b + 4) % 15)) : 4'($urandom % 16);
        if (n < 8) begin
          bank[b] = cb[n];
          bank[c] = cc[n];
        end else if (n % 5 == 0) begin
          bank[b] = $urandom;
          if (c != 0) bank[c] = bank[b];
        end else begin
          bank[b] = $urandom;
          if (c != 0) bank[c] = $urandom;
        end
        run(mk(MAJ, 2'(p), 2'b00, d, c, b, a, MIN));
      end
    end

    // R8 non-zero padding
    for (int q = 1; q < 4; q++) begin
      run(mk(MAJ, 2'(q), 2'(q), 4'd3, 4'd2, 4'd1, 4'd4, MIN));
    end

    // R9 zero destinations: each alone and both
    bank[7] = 32'hFFFF0000; bank[8] = 32'h00020000;
    run(mk(MAJ, 2'b00, 2'b00, 4'd9, 4'd8, 4'd7, 4'd0, MIN));
    bank[7] = 32'h00000001; bank[8] = 32'h00000002;
    run(mk(MAJ, 2'b11, 2'b00, 4'd0, 4'd8, 4'd7, 4'd9, MIN));
    run(mk(MAJ, 2'b10, 2'b00, 4'd0, 4'd8, 4'd7, 4'd0, MIN));

    // R1 unmatched opcodes
    run(mk(MAJ, 2'b00, 2'b00, 4'd5, 4'd6, 4'd7, 4'd8, 6'h17));
    run(mk(MAJ, 2'b00, 2'b00, 4'd5, 4'd6, 4'd7, 4'd8, 6'h19));
    run(mk(6'h1D, 2'b00, 2'b00, 4'd5, 4'd6, 4'd7, 4'd8, MIN));
    // R1 field placement with distinct indices
    bank[11] = 32'd100; bank[12] = 32'd30;
    run(mk(MAJ, 2'b01, 2'b00, 4'd13, 4'd12, 4'd11, 4'd14, MIN));
    chk("R1 a=b+c", bank[14], 32'd130);
    chk("R1 d=b-c", bank[13], 32'd70);

    // R10 zero source with junk on the read bus
    bank[5] = 32'h0000_1234;
    run(mk(MAJ, 2'b00, 2'b00, 4'd6, 4'd5, 4'd0, 4'd4, MIN));
    chk("R10 b=0 sum", wr_data_a, 32'h0000_1234);
    run(mk(MAJ, 2'b11, 2'b00, 4'd6, 4'd0, 4'd5, 4'd4, MIN));
    chk("R10 c=0 diff", wr_data_d, 32'h0000_1234);

    // R2 pulse ends when no instruction follows
    @(posedge clk);
    @(negedge clk);
    chk("R2 done pulse width", {31'd0, done}, 32'd0);
    chk("R2 idle writes", {30'd0, wr_en_a, wr_en_d}, 32'd0);
    chk("R7 ctrl idle", ctrl_q, exp_ctrl);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule